// File: doc/BRIEF.md
# Serial Memory Status and Write-Guard Unit

This unit holds the status byte of a small serial nonvolatile memory and decides whether each write is allowed. The serial command engine decodes frames from the host and sends this unit single-cycle events: set the write latch, clear the write latch, write the status byte with a data value, commit an array write at an address, and start or end a self-timed programming cycle. The unit answers each array commit and each status write with a one-cycle grant or deny pulse, and it always presents the current status byte for the engine to shift out.

Three conditions can stop a write. A volatile write latch must be set before any write is allowed, and it clears itself after each write it permits. A two-bit block-protect code fences off the top quarter, the top half or all of the array, and the whole page that holds the commit address is checked against that range. A lock bit stops status writes only while the external write-protect pin is low. The block-protect bits and the lock bit are treated as nonvolatile. The reset input loads them from parameters in place of stored contents.

Top module: `status_guard`

## Requirements
- R1: After reset the status byte reads {RST_LOCKEN, 3'b000, RST_BP, 1'b0, 1'b0}, and all four grant/deny outputs are 0. Reset is asynchronous on assertion and is released synchronously after two clock edges.
- R2: Status bit 1 is the write latch. It reads 1 on the cycle after an enable event and 0 on the cycle after a disable event. Disable wins when both arrive in the same cycle. Both events act whatever the lock bit, the WP pin and the busy flag are.
- R3: While bit 1 is 0, every array commit and every status write is denied and the status byte is left unchanged.
- R4: Block-protect bits 3:2 select the protected range: 00 none, 01 the top quarter (0x300-0x3FF), 10 the top half (0x200-0x3FF), 11 the whole array. A commit is granted only if the latch is set, no cycle is busy, and the whole page that holds the address lies outside the range. A granted commit clears the latch. A denied commit leaves the latch unchanged.
- R5: A status write is denied when bit 7 (the lock bit) is 1 and wp_pin_i is 0. Otherwise it is granted, subject to R3 and R6. A granted status write loads data bits 7, 3 and 2 and clears the latch. Bits 6:4 always read 0.
- R6: Status bit 0 reads 1 from the cycle after a busy-start event until the cycle after a busy-end event. While it is 1, commits and status writes are denied and the latch is unchanged.
- R7: When wp_pin_i changes after a status write has been granted, the stored bits 7, 3 and 2 do not change.
- R8: Each commit or status-write event gives exactly one of its grant/deny pulses, one cycle later and one cycle long. No pulse appears without an event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wren_i | input | 1 | Set-latch event |
| cmd_wrdi_i | input | 1 | Clear-latch event |
| sr_wr_i | input | 1 | Status-write event |
| sr_data_i | input | 8 | Data for a status write |
| arr_commit_i | input | 1 | Array-write commit event |
| arr_addr_i | input | ADDR_W (10) | Byte address of the commit |
| busy_start_i | input | 1 | A self-timed cycle begins |
| busy_end_i | input | 1 | A self-timed cycle ends |
| wp_pin_i | input | 1 | Write-protect pin; low may lock the status byte |
| status_o | output | 8 | Status byte |
| arr_grant_o | output | 1 | Commit granted pulse |
| arr_deny_o | output | 1 | Commit denied pulse |
| sr_grant_o | output | 1 | Status write granted pulse |
| sr_deny_o | output | 1 | Status write denied pulse |

## Verification
Every result comes from a register one edge after its event. The status byte, the grant pulses and the deny pulses all show the outcome on the cycle after the event. The bench drives each event on a falling edge, removes it on the next falling edge, and checks all outputs at that same moment, which falls between the edge that computed the result and the next one. Reset is checked the same way after the two-edge release. The WP-after-grant check holds the pin low for two full cycles before it reads the status byte.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int STATUS_W = 8;

  typedef struct packed {
    logic       lock_en;
    logic [2:0] rsvd;
    logic [1:0] bp;
    logic       wel;
    logic       wip;
  } sg_status_t;

  localparam logic [1:0] BP_NONE    = 2'b00;
  localparam logic [1:0] BP_QUARTER = 2'b01;
  localparam logic [1:0] BP_HALF    = 2'b10;
  localparam logic [1:0] BP_ALL     = 2'b11;
endpackage

// File: rtl/sg_write_latch.sv
module sg_write_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic disable_i,
  input  logic enable_i,
  input  logic consume_i,
  output logic q_o
);
  logic q_d;
  logic q_en;

  always_comb begin
    q_en = disable_i | enable_i | consume_i;
    if (disable_i)     q_d = 1'b0;
    else if (enable_i) q_d = 1'b1;
    else               q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_o <= 1'b0;
    else if (q_en) q_o <= q_d;
  end
endmodule

// File: rtl/sg_region_check.sv
module sg_region_check #(
  parameter int ADDR_W = 10,
  parameter int PAGE_W = 4
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        bp_i,
  output logic              page_clear_o
);
  localparam logic [ADDR_W-1:0] PAGE_MASK = ADDR_W'((1 << PAGE_W) - 1);
  localparam logic [ADDR_W-1:0] QUARTER   = ADDR_W'(1 << (ADDR_W - 2));
  localparam logic [ADDR_W-1:0] FLOOR_Q   = ADDR_W'(3) * QUARTER;
  localparam logic [ADDR_W-1:0] FLOOR_H   = ADDR_W'(2) * QUARTER;

  logic [ADDR_W-1:0] page_last;
  logic [ADDR_W-1:0] floor_addr;
  logic              any_prot;

  always_comb begin
    page_last = addr_i | PAGE_MASK;
    any_prot  = 1'b1;
    case (bp_i)
      sg_pkg::BP_QUARTER: floor_addr = FLOOR_Q;
      sg_pkg::BP_HALF:    floor_addr = FLOOR_H;
      sg_pkg::BP_ALL:     floor_addr = '0;
      default: begin
        floor_addr = '0;
        any_prot   = 1'b0;
      end
    endcase
    page_clear_o = !any_prot || (page_last < floor_addr);
  end
endmodule

// File: rtl/sg_status_bits.sv
module sg_status_bits #(
  parameter logic [1:0] RST_BP     = 2'b00,
  parameter logic       RST_LOCKEN = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load_i,
  input  logic [7:0] data_i,
  input  logic       busy_set_i,
  input  logic       busy_clr_i,
  output logic       lock_en_o,
  output logic [1:0] bp_o,
  output logic       wip_o
);
  logic       wip_d;
  logic       wip_en;
  logic       unused_data;

  assign unused_data = ^{data_i[6:4], data_i[1:0]};

  always_comb begin
    wip_en = busy_set_i | busy_clr_i;
    wip_d  = busy_set_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_en_o <= RST_LOCKEN;
      bp_o      <= RST_BP;
    end else if (load_i) begin
      lock_en_o <= data_i[7];
      bp_o      <= data_i[3:2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wip_o <= 1'b0;
    else if (wip_en) wip_o <= wip_d;
  end
endmodule

// File: rtl/status_guard.sv
module status_guard
  import sg_pkg::*;
#(
  parameter int         ADDR_W     = 10,
  parameter int         PAGE_W     = 4,
  parameter logic [1:0] RST_BP     = 2'b00,
  parameter logic       RST_LOCKEN = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren_i,
  input  logic              cmd_wrdi_i,
  input  logic              sr_wr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              arr_commit_i,
  input  logic [ADDR_W-1:0] arr_addr_i,
  input  logic              busy_start_i,
  input  logic              busy_end_i,
  input  logic              wp_pin_i,
  output logic [7:0]        status_o,
  output logic              arr_grant_o,
  output logic              arr_deny_o,
  output logic              sr_grant_o,
  output logic              sr_deny_o
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       wel;
  logic       wip;
  logic       lock_en;
  logic [1:0] bp;
  logic       page_clear;
  logic       arr_ok;
  logic       sr_ok;
  logic       sr_locked;
  logic [3:0] pulse_d;
  sg_status_t st;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  sg_region_check #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) region_i (
    .addr_i       (arr_addr_i),
    .bp_i         (bp),
    .page_clear_o (page_clear)
  );

  always_comb begin
    sr_locked = lock_en & ~wp_pin_i;
    arr_ok    = arr_commit_i & wel & ~wip & page_clear;
    sr_ok     = sr_wr_i & wel & ~wip & ~sr_locked;
    pulse_d   = {arr_ok, arr_commit_i & ~arr_ok, sr_ok, sr_wr_i & ~sr_ok};
  end

  sg_write_latch latch_i (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .disable_i (cmd_wrdi_i),
    .enable_i  (cmd_wren_i),
    .consume_i (arr_ok | sr_ok),
    .q_o       (wel)
  );

  sg_status_bits #(.RST_BP(RST_BP), .RST_LOCKEN(RST_LOCKEN)) bits_i (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .load_i     (sr_ok),
    .data_i     (sr_data_i),
    .busy_set_i (busy_start_i),
    .busy_clr_i (busy_end_i),
    .lock_en_o  (lock_en),
    .bp_o       (bp),
    .wip_o      (wip)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) {arr_grant_o, arr_deny_o, sr_grant_o, sr_deny_o} <= 4'b0000;
    else            {arr_grant_o, arr_deny_o, sr_grant_o, sr_deny_o} <= pulse_d;
  end

  always_comb begin
    st.lock_en = lock_en;
    st.rsvd    = 3'b000;
    st.bp      = bp;
    st.wel     = wel;
    st.wip     = wip;
    status_o   = st;
  end
endmodule

// File: rtl/sg_checker.sv
module sg_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wren_i,
  input logic       cmd_wrdi_i,
  input logic       sr_wr_i,
  input logic       arr_commit_i,
  input logic       wp_pin_i,
  input logic [7:0] status_o,
  input logic       arr_grant_o,
  input logic       arr_deny_o,
  input logic       sr_grant_o,
  input logic       sr_deny_o
);
  assert_wren_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wren_i && !cmd_wrdi_i |=> status_o[1]);
  assert_wrdi_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wrdi_i |=> !status_o[1]);
  assert_no_latch_deny_R3: assert property (@(posedge clk) disable iff (!rst_n)
    arr_commit_i && !status_o[1] |=> arr_deny_o);
  assert_grant_consumes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    arr_grant_o && !$past(cmd_wren_i) |-> !status_o[1]);
  assert_pin_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_i && status_o[7] && !wp_pin_i |=> sr_deny_o);
  assert_rsvd_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[6:4] == 3'b000);
  assert_busy_deny_R6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_commit_i && status_o[0] |=> arr_deny_o);
  assert_nv_only_by_grant_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({status_o[7], status_o[3:2]}) |-> sr_grant_o);
  assert_arr_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    arr_commit_i |=> (arr_grant_o != arr_deny_o));
  assert_arr_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !arr_commit_i |=> !arr_grant_o && !arr_deny_o);
  assert_sr_one_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    sr_wr_i |=> (sr_grant_o != sr_deny_o));
endmodule

bind status_guard sg_checker chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_wren_i   (cmd_wren_i),
  .cmd_wrdi_i   (cmd_wrdi_i),
  .sr_wr_i      (sr_wr_i),
  .arr_commit_i (arr_commit_i),
  .wp_pin_i     (wp_pin_i),
  .status_o     (status_o),
  .arr_grant_o  (arr_grant_o),
  .arr_deny_o   (arr_deny_o),
  .sr_grant_o   (sr_grant_o),
  .sr_deny_o    (sr_deny_o)
);

// File: tb/status_guard_tb_top.sv
module status_guard_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 29;
  // {req[37:34], op[33:31], wp[30], addr[29:20], data[19:12], exp_status[11:4], exp {ag,ad,sg,sd}[3:0]}
  // op: 0 idle, 1 enable, 2 disable, 3 status write, 4 commit, 5 busy start, 6 busy end
  localparam logic [37:0] VEC [NVEC] = '{
    {4'd3, 3'd4, 1'b1, 10'h000, 8'h00, 8'h00, 4'b0100}, // R3 commit, latch clear
    {4'd3, 3'd3, 1'b1, 10'h000, 8'h8C, 8'h00, 4'b0001}, // R3 status write, latch clear
    {4'd2, 3'd1, 1'b1, 10'h000, 8'h00, 8'h02, 4'b0000}, // R2 enable
    {4'd5, 3'd3, 1'b1, 10'h000, 8'hFC, 8'h8C, 4'b0010}, // R5 only bits 7,3,2 stored
    {4'd2, 3'd1, 1'b1, 10'h000, 8'h00, 8'h8E, 4'b0000}, // R2
    {4'd4, 3'd4, 1'b1, 10'h000, 8'h00, 8'h8E, 4'b0100}, // R4 code 11 all protected
    {4'd5, 3'd3, 1'b0, 10'h000, 8'h04, 8'h8E, 4'b0001}, // R5 locked by pin low
    {4'd2, 3'd2, 1'b0, 10'h000, 8'h00, 8'h8C, 4'b0000}, // R2 disable acts while locked
    {4'd2, 3'd1, 1'b0, 10'h000, 8'h00, 8'h8E, 4'b0000}, // R2 enable acts while locked
    {4'd5, 3'd3, 1'b1, 10'h000, 8'h04, 8'h04, 4'b0010}, // R5 pin high unlocks
    {4'd2, 3'd1, 1'b1, 10'h000, 8'h00, 8'h06, 4'b0000}, // R2
    {4'd4, 3'd4, 1'b1, 10'h300, 8'h00, 8'h06, 4'b0100}, // R4 code 01 top quarter
    {4'd4, 3'd4, 1'b1, 10'h2F5, 8'h00, 8'h04, 4'b1000}, // R4 just below quarter
    {4'd2, 3'd1, 1'b1, 10'h000, 8'h00, 8'h06, 4'b0000}, // R2
    {4'd5, 3'd3, 1'b0, 10'h000, 8'h08, 8'h08, 4'b0010}, // R5 lock bit 0, pin ignored
    {4'd2, 3'd1, 1'b1, 10'h000, 8'h00, 8'h0A, 4'b0000}, // R2
    {4'd4, 3'd4, 1'b1, 10'h200, 8'h00, 8'h0A, 4'b0100}, // R4 code 10 top half
    {4'd4, 3'd4, 1'b1, 10'h1FF, 8'h00, 8'h08, 4'b1000}, // R4 just below half
    {4'd6, 3'd5, 1'b1, 10'h000, 8'h00, 8'h09, 4'b0000}, // R6 busy start
    {4'd2, 3'd1, 1'b1, 10'h000, 8'h00, 8'h0B, 4'b0000}, // R2 enable while busy
    {4'd6, 3'd4, 1'b1, 10'h000, 8'h00, 8'h0B, 4'b0100}, // R6 commit while busy
    {4'd6, 3'd3, 1'b1, 10'h000, 8'h00, 8'h0B, 4'b0001}, // R6 status write while busy
    {4'd6, 3'd6, 1'b1, 10'h000, 8'h00, 8'h0A, 4'b0000}, // R6 busy end
    {4'd2, 3'd2, 1'b1, 10'h000, 8'h00, 8'h08, 4'b0000}, // R2 disable
    {4'd8, 3'd0, 1'b1, 10'h000, 8'h00, 8'h08, 4'b0000}, // R8 no event, no pulse
    {4'd2, 3'd1, 1'b1, 10'h000, 8'h00, 8'h0A, 4'b0000}, // R2
    {4'd5, 3'd3, 1'b1, 10'h000, 8'h00, 8'h00, 4'b0010}, // R5 clear protection
    {4'd2, 3'd1, 1'b1, 10'h000, 8'h00, 8'h02, 4'b0000}, // R2
    {4'd4, 3'd4, 1'b1, 10'h3FF, 8'h00, 8'h00, 4'b1000}  // R4 code 00 top address
  };

  logic       clk;
  logic       rst_n;
  logic       wren, wrdi, srwr, commit, bstart, bend, wp;
  logic [7:0] sdata;
  logic [9:0] addr;
  logic [7:0] status, status_alt;
  logic       ag, ad, sg, sd;
  logic       ag2, ad2, sg2, sd2;
  int         n_tests;
  int         n_fail;

  status_guard dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_wren_i(wren), .cmd_wrdi_i(wrdi),
    .sr_wr_i(srwr), .sr_data_i(sdata), .arr_commit_i(commit), .arr_addr_i(addr),
    .busy_start_i(bstart), .busy_end_i(bend), .wp_pin_i(wp),
    .status_o(status), .arr_grant_o(ag), .arr_deny_o(ad),
    .sr_grant_o(sg), .sr_deny_o(sd)
  );

  status_guard #(.RST_BP(2'b10), .RST_LOCKEN(1'b1)) dut_alt_i (
    .clk(clk), .rst_n(rst_n), .cmd_wren_i(1'b0), .cmd_wrdi_i(1'b0),
    .sr_wr_i(1'b0), .sr_data_i(8'h00), .arr_commit_i(1'b0), .arr_addr_i(10'h000),
    .busy_start_i(1'b0), .busy_end_i(1'b0), .wp_pin_i(1'b1),
    .status_o(status_alt), .arr_grant_o(ag2), .arr_deny_o(ad2),
    .sr_grant_o(sg2), .sr_deny_o(sd2)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    {wren, wrdi, srwr, commit, bstart, bend} = '0;
    sdata = 8'h00;
    addr  = 10'h000;
    wp    = 1'b1;
  endtask

  task automatic drive(input logic [2:0] op, input logic pin, input logic [9:0] a,
                       input logic [7:0] d);
    idle_inputs();
    wp = pin; addr = a; sdata = d;
    case (op)
      3'd1: wren   = 1'b1;
      3'd2: wrdi   = 1'b1;
      3'd3: srwr   = 1'b1;
      3'd4: commit = 1'b1;
      3'd5: bstart = 1'b1;
      3'd6: bend   = 1'b1;
      default: ;
    endcase
  endtask

  initial begin
    n_tests = 0;
    n_fail  = 0;
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, default and alternate parameters
    check("R1", {status, ag, ad, sg, sd}, {8'h00, 4'b0000});
    check("R1", {status_alt, ag2, ad2, sg2, sd2}, {8'h88, 4'b0000});

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      drive(VEC[i][33:31], VEC[i][30], VEC[i][29:20], VEC[i][19:12]);
      @(negedge clk);
      idle_inputs();
      check($sformatf("R%0d vec %0d", VEC[i][37:34], i),
            {status, ag, ad, sg, sd}, VEC[i][11:0]);
    end

    // R7: pin falling after a granted status write leaves stored bits alone
    @(negedge clk); drive(3'd1, 1'b1, 10'h000, 8'h00);
    @(negedge clk); drive(3'd3, 1'b1, 10'h000, 8'h84);
    @(negedge clk); idle_inputs();
    check("R7 grant", {status, ag, ad, sg, sd}, {8'h84, 4'b0010});
    drive(3'd5, 1'b1, 10'h000, 8'h00);
    @(negedge clk); idle_inputs(); wp = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 pin low", {status, ag, ad, sg, sd}, {8'h85, 4'b0000});
    wp = 1'b1;
    drive(3'd6, 1'b1, 10'h000, 8'h00);
    @(negedge clk); idle_inputs();
    check("R6 end", {status, ag, ad, sg, sd}, {8'h84, 4'b0000});

    // R2: disable wins over enable in the same cycle
    drive(3'd1, 1'b1, 10'h000, 8'h00); wrdi = 1'b1;
    @(negedge clk); idle_inputs();
    check("R2 both", {status, ag, ad, sg, sd}, {8'h84, 4'b0000});

    // R1: reset in mid-run restores parameter values
    drive(3'd1, 1'b1, 10'h000, 8'h00);
    @(negedge clk); idle_inputs();
    check("R2 set", {status, ag, ad, sg, sd}, {8'h86, 4'b0000});
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 mid", {status, ag, ad, sg, sd}, {8'h00, 4'b0000});
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after", {status, ag, ad, sg, sd}, {8'h00, 4'b0000});

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule